// File: doc/BRIEF.md
# Burst Memory Write/Read Scheduler

This block decides, one burst at a time, whether the memory controller should move pixel data out of the write FIFO or into the read FIFO. It watches the fill levels of both FIFOs and raises a single command toward the controller. Each command carries a byte address, built from a per-direction frame base plus a running offset, and a 4-bit command code. While a write burst runs it pops the write FIFO on every data-ready beat and presents each word two cycles after that beat. While a read burst runs it forwards the returned words into the read FIFO.

Writes win whenever the write FIFO reaches half full. A write sequence then continues burst after burst until less than one burst of data remains. Reads refill the read FIFO toward half full, and only when no write is due. The direction can change only when a burst is complete.

An optional address permutation moves the bank bits below the upper column bits, so that consecutive bursts land in different banks. When the permutation is on, the auto-precharge command codes are used.

Top module: `burst_sched`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, write_cmd, read_cmd, wfifo_pop and rfifo_push are 0 and mem_cmd is 4'b0000.
- R2: A write burst is requested when the scheduler is idle and wfifo_level is at least half of FIFO_DEPTH (32 by default), provided at least BEATS (4) words are present. write_cmd rises in the cycle after the idle cycle that saw those levels.
- R3: Once a write burst has been chosen, the next idle decision chooses another write whenever wfifo_level is at least BEATS, even below half full. When fewer than BEATS words remain, the write sequence ends and a read may be chosen.
- R4: A read burst is requested only if no write is chosen, wfifo_level is below half, rfifo_level is below half, and rfifo_level leaves room for BEATS words. Otherwise no command is raised.
- R5: write_cmd and read_cmd are never high together. A command stays high, with a stable address, until it is sampled together with cmd_ready. After it is accepted, no new command appears until that burst's BEATS data beats are complete.
- R6: During a write burst, each write_data_ready beat pops the write FIFO, and the popped word appears on write_data two cycles after the beat. Outside a write burst, write_data_ready pops nothing and leaves write_data unchanged.
- R7: The write and read offsets each advance by BEATS*DATA_W/8 bytes (16 by default) per accepted burst. An offset returns to 0 when the next step would reach frame_bytes. A frame_start pulse returns both offsets to 0.
- R8: With REMAP set, the linear address {row, colhi[7:0], bank[2:0], collo[1:0], byte[1:0]} (LSB right) is output as {row, bank, colhi, collo, byte}. Bit 4 of the linear address therefore becomes bit 12 of mem_addr. With REMAP clear, the linear address is output unchanged.
- R9: mem_cmd is 4'b0100 for a write and 4'b0011 for a read when REMAP is set, and 4'b0010 and 4'b0001 when it is clear. It is 4'b0000 when no command is raised.
- R10: During a read burst, each read_data_valid beat raises rfifo_push in the same cycle, with rfifo_data equal to read_data. A read burst ends after BEATS beats. Outside a read burst, read_data_valid pushes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Pulse that returns both offsets to 0 |
| wr_base | input | ADDR_W | Byte base of the frame slot being written |
| rd_base | input | ADDR_W | Byte base of the frame slot being read |
| frame_bytes | input | ADDR_W | Frame size in bytes; offsets wrap here |
| wfifo_level | input | LVL_W | Words held in the write FIFO |
| rfifo_level | input | LVL_W | Words held in the read FIFO |
| wfifo_pop | output | 1 | Write FIFO read strobe; data is expected the next cycle |
| wfifo_data | input | DATA_W | Word returned by the write FIFO |
| rfifo_push | output | 1 | Read FIFO write strobe |
| rfifo_data | output | DATA_W | Word pushed into the read FIFO |
| cmd_ready | input | 1 | Controller accepts the pending command |
| write_cmd | output | 1 | Write burst request |
| read_cmd | output | 1 | Read burst request |
| mem_cmd | output | 4 | Command code for the pending request |
| mem_addr | output | ADDR_W | Byte address of the pending request |
| write_data_ready | input | 1 | Controller takes one write word |
| write_data | output | DATA_W | Write word, two cycles after its ready beat |
| read_data | input | DATA_W | Word returned by the controller |
| read_data_valid | input | 1 | read_data holds a valid word |

## Verification
A wrong write-mode flag shows up at the next idle decision. It appears one cycle later as a write request where a read was due, or the other way round, so each row of the level table shows it within a cycle. A slipped beat counter ends a burst early or late. That surfaces as a command rising while data beats are still being driven, or as a hung request that never rises again. A wrong offset or a wrong permutation shows in mem_addr on the very next request. The frame size is three bursts long, so the wrap is reached within a few bursts in each direction.

// File: rtl/burst_sched.sv
`timescale 1ns/1ps
module burst_sched #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int BEATS      = 4,
  parameter int FIFO_DEPTH = 64,
  parameter int BYTE_W     = 2,
  parameter int COLLO_W    = 2,
  parameter int BANK_W     = 3,
  parameter int COLHI_W    = 8,
  parameter bit REMAP      = 1'b1,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] rd_base,
  input  logic [ADDR_W-1:0] frame_bytes,
  input  logic [LVL_W-1:0]  wfifo_level,
  input  logic [LVL_W-1:0]  rfifo_level,
  output logic              wfifo_pop,
  input  logic [DATA_W-1:0] wfifo_data,
  output logic              rfifo_push,
  output logic [DATA_W-1:0] rfifo_data,
  input  logic              cmd_ready,
  output logic              write_cmd,
  output logic              read_cmd,
  output logic [3:0]        mem_cmd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              write_data_ready,
  output logic [DATA_W-1:0] write_data,
  input  logic [DATA_W-1:0] read_data,
  input  logic              read_data_valid
);
  localparam int CNT_W = $clog2(BEATS);
  localparam int ROW_LSB = BYTE_W + COLLO_W + BANK_W + COLHI_W;
  localparam logic [LVL_W-1:0]  HALF_L  = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [LVL_W-1:0]  BEATS_L = LVL_W'(BEATS);
  localparam logic [LVL_W-1:0]  ROOM_L  = LVL_W'(FIFO_DEPTH - BEATS);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(BEATS * (DATA_W / 8));
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(BEATS - 1);
  localparam logic [3:0] WR_CODE = REMAP ? 4'b0100 : 4'b0010;
  localparam logic [3:0] RD_CODE = REMAP ? 4'b0011 : 4'b0001;

  typedef enum logic [2:0] {S_IDLE, S_WCMD, S_WDAT, S_RCMD, S_RDAT} st_t;

  st_t               state;
  logic              wr_mode;
  logic [CNT_W-1:0]  beat;
  logic [ADDR_W-1:0] wr_off, rd_off, lin;
  logic              wr_act, rd_ok;

  assign wr_act = (wr_mode || wfifo_level >= HALF_L) && wfifo_level >= BEATS_L;
  assign rd_ok  = wfifo_level < HALF_L && rfifo_level < HALF_L && rfifo_level <= ROOM_L;

  assign write_cmd  = state == S_WCMD;
  assign read_cmd   = state == S_RCMD;
  assign mem_cmd    = write_cmd ? WR_CODE : (read_cmd ? RD_CODE : 4'b0000);
  assign wfifo_pop  = write_data_ready && state == S_WDAT;
  assign rfifo_push = read_data_valid && state == S_RDAT;
  assign rfifo_data = read_data;
  assign lin        = read_cmd ? rd_base + rd_off : wr_base + wr_off;

  generate
    if (REMAP) begin : g_remap
      assign mem_addr = {lin[ADDR_W-1:ROW_LSB],
                         lin[BYTE_W+COLLO_W +: BANK_W],
                         lin[BYTE_W+COLLO_W+BANK_W +: COLHI_W],
                         lin[BYTE_W +: COLLO_W],
                         lin[BYTE_W-1:0]};
    end else begin : g_linear
      assign mem_addr = lin;
    end
  endgenerate

  function automatic logic [ADDR_W-1:0] step_off(input logic [ADDR_W-1:0] off,
                                                 input logic [ADDR_W-1:0] size);
    return (off + STEP >= size) ? '0 : off + STEP;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wr_mode    <= 1'b0;
      beat       <= '0;
      wr_off     <= '0;
      rd_off     <= '0;
      write_data <= '0;
    end else begin
      write_data <= wfifo_data;
      case (state)
        S_IDLE: begin
          wr_mode <= wr_act;
          beat    <= '0;
          if (wr_act)     state <= S_WCMD;
          else if (rd_ok) state <= S_RCMD;
        end
        S_WCMD: if (cmd_ready) state <= S_WDAT;
        S_RCMD: if (cmd_ready) state <= S_RDAT;
        S_WDAT: if (write_data_ready) begin
          beat <= beat + 1'b1;
          if (beat == LAST) state <= S_IDLE;
        end
        S_RDAT: if (read_data_valid) begin
          beat <= beat + 1'b1;
          if (beat == LAST) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (frame_start) begin
        wr_off <= '0;
        rd_off <= '0;
      end else begin
        if (write_cmd && cmd_ready) wr_off <= step_off(wr_off, frame_bytes);
        if (read_cmd && cmd_ready)  rd_off <= step_off(rd_off, frame_bytes);
      end
    end
  end
endmodule

// File: rtl/burst_sched_chk.sv
`timescale 1ns/1ps
module burst_sched_chk #(
  parameter int ADDR_W     = 32,
  parameter int BEATS      = 4,
  parameter int FIFO_DEPTH = 64,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              write_cmd,
  input logic              read_cmd,
  input logic              cmd_ready,
  input logic [3:0]        mem_cmd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LVL_W-1:0]  wfifo_level,
  input logic [LVL_W-1:0]  rfifo_level,
  input logic              write_data_ready,
  input logic              wfifo_pop,
  input logic              read_data_valid,
  input logic              rfifo_push
);
  localparam logic [LVL_W-1:0] HALF_L  = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [LVL_W-1:0] BEATS_L = LVL_W'(BEATS);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(write_cmd && read_cmd));
  p_whold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (write_cmd && !cmd_ready) |=> (write_cmd && $stable(mem_addr)));
  p_rhold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (read_cmd && !cmd_ready) |=> (read_cmd && $stable(mem_addr)));
  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((write_cmd || read_cmd) && cmd_ready) |=> !(write_cmd || read_cmd));
  p_wgate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_cmd) |-> $past(wfifo_level) >= BEATS_L);
  p_rgate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_cmd) |-> ($past(rfifo_level) < HALF_L && $past(wfifo_level) < HALF_L));
  p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wfifo_pop |-> (write_data_ready && !write_cmd && !read_cmd));
  p_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rfifo_push |-> (read_data_valid && !write_cmd && !read_cmd));
  p_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (write_cmd || read_cmd) == (mem_cmd != 4'b0000));
endmodule

bind burst_sched burst_sched_chk #(
  .ADDR_W(ADDR_W), .BEATS(BEATS), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .write_cmd(write_cmd), .read_cmd(read_cmd),
  .cmd_ready(cmd_ready), .mem_cmd(mem_cmd), .mem_addr(mem_addr),
  .wfifo_level(wfifo_level), .rfifo_level(rfifo_level),
  .write_data_ready(write_data_ready), .wfifo_pop(wfifo_pop),
  .read_data_valid(read_data_valid), .rfifo_push(rfifo_push)
);

// File: tb/test_burst_sched.sv
`timescale 1ns/1ps
module test_burst_sched;
  localparam int CLK_P = 10;
  localparam logic [31:0] WBASE = 32'h1000_0000;
  localparam logic [31:0] RBASE = 32'h2000_0000;
  // rows: write level, read level, expected (0 none, 1 write, 2 read)
  localparam int NROWS = 12;
  localparam int ROWS [NROWS][3] = '{
    '{0, 40, 0}, '{10, 10, 2}, '{32, 0, 1}, '{20, 0, 1},
    '{4, 0, 1},  '{3, 0, 2},   '{20, 0, 2}, '{31, 31, 2},
    '{31, 32, 0}, '{64, 64, 1}, '{3, 40, 0}, '{0, 0, 2}};

  logic clk = 0, rst_n = 0, frame_start = 0;
  logic [31:0] wr_base = WBASE, rd_base = RBASE, frame_bytes = 32'd48;
  logic [6:0] wfifo_level = 0, rfifo_level = 7'd64;
  logic wfifo_pop, rfifo_push, cmd_ready = 0, write_cmd, read_cmd;
  logic [31:0] wfifo_data, rfifo_data, mem_addr, write_data, read_data = 0;
  logic [3:0] mem_cmd;
  logic write_data_ready = 0, read_data_valid = 0;
  logic [31:0] wseq;
  int checks = 0, fails = 0;
  bit done = 0;
  int w_off = 0, r_off = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin wseq <= 32'd100; wfifo_data <= 32'd0; end
    else if (wfifo_pop) begin wfifo_data <= wseq; wseq <= wseq + 1; end

  burst_sched i_burst_sched (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .wr_base(wr_base), .rd_base(rd_base), .frame_bytes(frame_bytes),
    .wfifo_level(wfifo_level), .rfifo_level(rfifo_level),
    .wfifo_pop(wfifo_pop), .wfifo_data(wfifo_data),
    .rfifo_push(rfifo_push), .rfifo_data(rfifo_data),
    .cmd_ready(cmd_ready), .write_cmd(write_cmd), .read_cmd(read_cmd),
    .mem_cmd(mem_cmd), .mem_addr(mem_addr),
    .write_data_ready(write_data_ready), .write_data(write_data),
    .read_data(read_data), .read_data_valid(read_data_valid));

  function automatic logic [31:0] bmap(input logic [31:0] a);
    return {a[31:15], a[6:4], a[14:7], a[3:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_row(input int wl, input int rl, input int exp, input int idx);
    logic [31:0] ea;
    wfifo_level = 7'(wl); rfifo_level = 7'(rl);
    @(negedge clk);
    chk(write_cmd == (exp == 1), $sformatf("R2/R3 row%0d write_cmd", idx), 32'(write_cmd), 32'(exp == 1));
    chk(read_cmd == (exp == 2), $sformatf("R4 row%0d read_cmd", idx), 32'(read_cmd), 32'(exp == 2));
    if (exp == 1) begin
      ea = bmap(WBASE + 32'(w_off));
      chk(mem_addr == ea, $sformatf("R7/R8 row%0d write addr", idx), mem_addr, ea);
      chk(mem_cmd == 4'b0100, "R9 write code", 32'(mem_cmd), 32'h4);
      w_off = (w_off + 16 >= 48) ? 0 : w_off + 16;
    end else if (exp == 2) begin
      ea = bmap(RBASE + 32'(r_off));
      chk(mem_addr == ea, $sformatf("R7/R8 row%0d read addr", idx), mem_addr, ea);
      chk(mem_cmd == 4'b0011, "R9 read code", 32'(mem_cmd), 32'h3);
      r_off = (r_off + 16 >= 48) ? 0 : r_off + 16;
    end else begin
      chk(mem_cmd == 4'b0000, "R9 idle code", 32'(mem_cmd), 32'h0);
    end
    if (exp != 0) begin
      cmd_ready = 1; @(negedge clk); cmd_ready = 0;
      for (int b = 0; b < 4; b++) begin
        if (exp == 1) write_data_ready = 1; else read_data_valid = 1;
        @(negedge clk);
        chk(!write_cmd && !read_cmd, "R5 no command mid-burst", 32'(write_cmd | read_cmd), 32'h0);
      end
      write_data_ready = 0; read_data_valid = 0;
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] wd0, first, ea;
    repeat (3) @(negedge clk);
    chk(!write_cmd && !read_cmd && mem_cmd == 0, "R1 reset outputs", {write_cmd, read_cmd, mem_cmd}, 0);
    chk(!wfifo_pop && !rfifo_push, "R1 reset strobes", {wfifo_pop, rfifo_push}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!write_cmd && !read_cmd && mem_cmd == 0, "R1 first idle", {write_cmd, read_cmd, mem_cmd}, 0);

    for (int r = 0; r < NROWS; r++) run_row(ROWS[r][0], ROWS[r][1], ROWS[r][2], r);

    // idle: data strobes ignored (R6, R10)
    wfifo_level = 0; rfifo_level = 7'd64;
    @(negedge clk);
    wd0 = write_data;
    write_data_ready = 1; read_data_valid = 1; read_data = 32'hABCD_0001;
    chk(!wfifo_pop, "R6 ready ignored when idle", 32'(wfifo_pop), 0);
    chk(!rfifo_push, "R10 valid ignored when idle", 32'(rfifo_push), 0);
    @(negedge clk);
    chk(write_data == wd0, "R6 write_data unchanged", write_data, wd0);
    write_data_ready = 0; read_data_valid = 0;

    // frame restart (R7)
    frame_start = 1; @(negedge clk); frame_start = 0;
    wfifo_level = 7'd40;
    @(negedge clk);
    ea = bmap(WBASE);
    chk(write_cmd && mem_addr == ea, "R7 write offset restarts", mem_addr, ea);
    // hold while not ready (R5)
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(write_cmd && !read_cmd && mem_addr == ea, "R5 command held", mem_addr, ea);
    end
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
    chk(!write_cmd, "R5 drop after accept", 32'(write_cmd), 0);
    // write data delay (R6)
    first = wseq;
    for (int i = 0; i < 6; i++) begin
      write_data_ready = (i < 4);
      if (i == 4) wfifo_level = 0;
      if (i >= 2) chk(write_data == first + 32'(i - 2), "R6 data two cycles after ready", write_data, first + 32'(i - 2));
      @(negedge clk);
    end
    write_data_ready = 0;
    chk(!write_cmd && !read_cmd, "R3 write sequence ended", {write_cmd, read_cmd}, 0);

    // read burst forwarding (R10)
    rfifo_level = 0;
    @(negedge clk);
    ea = bmap(RBASE);
    chk(read_cmd && mem_addr == ea, "R7 read offset restarts", mem_addr, ea);
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
    for (int b = 0; b < 4; b++) begin
      read_data_valid = 1; read_data = 32'h5000 + 32'(b);
      #1;
      chk(rfifo_push && rfifo_data == read_data, "R10 push with data", rfifo_data, read_data);
      @(negedge clk);
    end
    read_data_valid = 0; rfifo_level = 7'd64;
    @(negedge clk);
    chk(!write_cmd && !read_cmd, "R10 burst ended after four beats", {write_cmd, read_cmd}, 0);
    @(negedge clk);
    chk(!write_cmd && !read_cmd, "R4 full read FIFO stays idle", {write_cmd, read_cmd}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule